// File: doc/BRIEF.md
# Receiver Wake-up Status Register

This block collects the event and level indications of a three-channel low-frequency receiver front end and presents them as one 9-bit status word. Each channel contributes a live "passing data" flag and a sticky wake-up flag. The wake-up flag is raised by an internal per-channel qualifier that counts 64 carrier clock ticks without a break. The word also carries a live AGC-strong flag, a sticky alarm time-out flag and a live configuration parity-error flag. An active-low alert pin summarises the parity error and, when enabled, the alarm.

Each field has its own clearing rule. A status read clears only the alarm flag. A soft reset clears the channel and AGC fields but leaves the alarm and parity flags alone. A sleep command touches nothing. Power-on reset leaves the parity flag set. A status read returns the word as it stood before the read took effect. The analog front end, the alarm timer, the command decoder and the parity logic sit outside the block and deliver single-bit results.

Top module: `wsr_status_reg`

## Requirements
- R1: The status word, MSB first, is: active Z, active Y, active X (bits 8..6, channel index 2..0), AGC strong (bit 5), wake Z, wake Y, wake X (bits 4..2), alarm (bit 1), parity error (bit 0).
- R2: While in power-on reset, alert_n is 0 and rd_data is 0. A read issued on the first clock after reset returns 9'h001.
- R3: A read strobe loads rd_data on that clock edge with the word as it stood before the edge, and clears the alarm flag.
- R4: An alarm pulse sets the alarm flag on the next edge. The flag stays set until a read. If a read and an alarm pulse fall on the same edge, the flag stays set.
- R5: A sleep strobe changes no status bit.
- R6: A channel's wake flag sets on the 64th tick counted while its carrier is present. Ticks need not be consecutive while the carrier stays up. The flag then stays set until a soft reset.
- R7: Dropping a channel's carrier for one cycle restarts that channel's tick count from zero.
- R8: The active flags and the AGC flag take the value of their inputs one clock after the inputs change.
- R9: The parity flag takes the value of parity_err one clock later and is not changed by a soft reset.
- R10: A soft reset clears bits 8..2 and the wake counters on that edge, and leaves bits 1..0 unchanged.
- R11: alert_n is 0 exactly when the parity flag is 1, or when the alarm flag and alarm_alert_en are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ch_pass | input | 3 | Per-channel "passing data" level |
| ch_carrier | input | 3 | Per-channel carrier-present level |
| ch_tick | input | 3 | Per-channel carrier clock tick, one cycle per tick |
| agc_strong | input | 1 | AGC strong-signal level |
| alarm_pulse | input | 1 | Alarm time-out event |
| alarm_alert_en | input | 1 | Lets the alarm flag pull the alert low |
| parity_err | input | 1 | Configuration parity-error level |
| rd_strobe | input | 1 | Status read command |
| sleep_strobe | input | 1 | Sleep command |
| soft_rst | input | 1 | Soft reset command |
| rd_data | output | 9 | Status word captured by the last read |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench sweeps every pattern of the three active inputs and the AGC input. It drives each channel's qualifier to 63, 64 and 70 ticks, so a counter that is off by one raises wake on the wrong tick. It checks that a one-cycle carrier drop restarts the count and that a pause in the ticks with the carrier up does not. A design that clears the alarm before capturing the word, or lets a read win over a same-cycle alarm, loses an alarm event and is caught. So is a soft reset that also wipes the alarm or parity flags. The power-on word and a sleep between two reads are also compared against the expected fields.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
   localparam int PE_BIT    = 0;
   localparam int ALARM_BIT = 1;
   localparam int WAKE_LSB  = 2;

   function automatic int word_width(input int n_ch);
      return 2 * n_ch + 3;
   endfunction

   function automatic int agc_bit(input int n_ch);
      return WAKE_LSB + n_ch;
   endfunction
endpackage

// File: rtl/wsr_wake_qual.sv
module wsr_wake_qual #(
   parameter int QUAL_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic carrier,
   input  logic tick,
   output logic wake
);
   localparam logic [QUAL_W-1:0] TERM = {QUAL_W{1'b1}};

   logic [QUAL_W-1:0] cnt;
   logic              at_term;

   assign at_term = (cnt == TERM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wake <= 1'b0;
      end else if (soft_rst) begin
         cnt  <= '0;
         wake <= 1'b0;
      end else begin
         if (!carrier)
            cnt <= '0;
         else if (tick && !at_term)
            cnt <= cnt + 1'b1;
         if (carrier && tick && at_term)
            wake <= 1'b1;
      end
   end

   AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !soft_rst) |=> wake); // R6

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!carrier) |=> (cnt == '0)); // R7

   AST_NO_EARLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake && !at_term) |=> !wake); // R6
endmodule

// File: rtl/wsr_alarm_latch.sv
module wsr_alarm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_pulse,
   input  logic rd_strobe,
   output logic alarm_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         alarm_q <= 1'b0;
      else if (alarm_pulse)
         alarm_q <= 1'b1;
      else if (rd_strobe)
         alarm_q <= 1'b0;
   end

   AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |=> alarm_q); // R4

   AST_ALARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !alarm_pulse) |=> !alarm_q); // R3
endmodule

// File: rtl/wsr_live_flags.sv
module wsr_live_flags #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [NUM_CH-1:0] ch_pass,
   input  logic              agc_strong,
   input  logic              parity_err,
   output logic [NUM_CH-1:0] act_q,
   output logic              agc_q,
   output logic              pe_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         agc_q <= 1'b0;
      end else if (soft_rst) begin
         act_q <= '0;
         agc_q <= 1'b0;
      end else begin
         act_q <= ch_pass;
         agc_q <= agc_strong;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pe_q <= 1'b1;
      else
         pe_q <= parity_err;
   end

   AST_PE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pe_q == $past(parity_err))); // R9

   AST_ACT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst) |=> (act_q == $past(ch_pass))); // R8
endmodule

// File: rtl/wsr_status_reg.sv
module wsr_status_reg #(
   parameter int NUM_CH    = 3,
   parameter int QUAL_W    = 6,
   parameter bit ALERT_REG = 1'b0,
   localparam int WORD_W   = wsr_pkg::word_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_pass,
   input  logic [NUM_CH-1:0] ch_carrier,
   input  logic [NUM_CH-1:0] ch_tick,
   input  logic              agc_strong,
   input  logic              alarm_pulse,
   input  logic              alarm_alert_en,
   input  logic              parity_err,
   input  logic              rd_strobe,
   input  logic              sleep_strobe,
   input  logic              soft_rst,
   output logic [WORD_W-1:0] rd_data,
   output logic              alert_n
);
   import wsr_pkg::*;

   localparam int AGC_B   = agc_bit(NUM_CH);
   localparam int ACT_LSB = AGC_B + 1;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("wsr_status_reg: NUM_CH out of range");
   end
   if (QUAL_W < 1 || QUAL_W > 16) begin : g_bad_qual
      $error("wsr_status_reg: QUAL_W out of range");
   end

   logic [NUM_CH-1:0] wake;
   logic [NUM_CH-1:0] act_q;
   logic              agc_q;
   logic              pe_q;
   logic              alarm_q;
   logic [WORD_W-1:0] status;
   logic              alert_now;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      wsr_wake_qual #(.QUAL_W(QUAL_W)) u_qual (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .carrier  (ch_carrier[c]),
         .tick     (ch_tick[c]),
         .wake     (wake[c])
      );
   end

   wsr_alarm_latch u_alarm (
      .clk         (clk),
      .rst_n       (rst_n),
      .alarm_pulse (alarm_pulse),
      .rd_strobe   (rd_strobe),
      .alarm_q     (alarm_q)
   );

   wsr_live_flags #(.NUM_CH(NUM_CH)) u_live (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .ch_pass    (ch_pass),
      .agc_strong (agc_strong),
      .parity_err (parity_err),
      .act_q      (act_q),
      .agc_q      (agc_q),
      .pe_q       (pe_q)
   );

   always_comb begin
      status                             = '0;
      status[PE_BIT]                     = pe_q;
      status[ALARM_BIT]                  = alarm_q;
      status[WAKE_LSB +: NUM_CH]         = wake;
      status[AGC_B]                      = agc_q;
      status[ACT_LSB +: NUM_CH]          = act_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_strobe)
         rd_data <= status;
   end

   assign alert_now = pe_q | (alarm_q & alarm_alert_en);

   if (ALERT_REG) begin : g_alert_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alert_n <= 1'b0;
         else
            alert_n <= ~alert_now;
      end
   end else begin : g_alert_comb
      assign alert_n = ~alert_now;
   end

   AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (wake == '0 && act_q == '0 && !agc_q)); // R10

   AST_SOFT_KEEPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !rd_strobe && !alarm_pulse) |=> (alarm_q == $past(alarm_q))); // R10

   AST_SLEEP_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_strobe && !rd_strobe && !alarm_pulse) |=> (alarm_q == $past(alarm_q))); // R5

   AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> (rd_data[ALARM_BIT] == $past(alarm_q))); // R3
endmodule

// File: tb/wsr_status_reg_bench.sv
module wsr_status_reg_bench;
   localparam int NCH = 3;
   localparam int W   = 2 * NCH + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] ch_pass = '0, ch_carrier = '0, ch_tick = '0;
   logic           agc_strong = 0, alarm_pulse = 0, alarm_alert_en = 0;
   logic           parity_err = 0, rd_strobe = 0, sleep_strobe = 0, soft_rst = 0;
   logic [W-1:0]   rd_data;
   logic           alert_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   wsr_status_reg u_wsr_status_reg (
      .clk(clk), .rst_n(rst_n), .ch_pass(ch_pass), .ch_carrier(ch_carrier),
      .ch_tick(ch_tick), .agc_strong(agc_strong), .alarm_pulse(alarm_pulse),
      .alarm_alert_en(alarm_alert_en), .parity_err(parity_err),
      .rd_strobe(rd_strobe), .sleep_strobe(sleep_strobe), .soft_rst(soft_rst),
      .rd_data(rd_data), .alert_n(alert_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] word(input logic [2:0] act, input logic agc,
                                         input logic [2:0] wk, input logic al, input logic pe);
      return {act, agc, wk, al, pe};
   endfunction

   // called at a negedge; returns captured word at the following negedge
   task automatic do_read(output logic [W-1:0] v);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_soft();
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   task automatic ticks(input int ch, input int n);
      ch_carrier[ch] = 1'b1;
      for (int i = 0; i < n; i++) begin
         ch_tick[ch] = 1'b1;
         @(negedge clk);
      end
      ch_tick[ch] = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      logic [W-1:0] v2;
      int ns[3] = '{63, 64, 70};

      idle(3);
      chk("R2 alert_n in reset", {{(W-1){1'b0}}, alert_n}, '0);
      chk("R2 rd_data in reset", rd_data, '0);
      rst_n = 1'b1;
      do_read(v);
      chk("R2 first read after reset", v, 9'h001);
      chk("R9 parity follows low input", {{(W-1){1'b0}}, alert_n}, 1);

      // R8 / R1: sweep live active and AGC inputs
      for (int p = 0; p < 16; p++) begin
         ch_pass = p[2:0];
         agc_strong = p[3];
         @(negedge clk);
         do_read(v);
         chk("R8 R1 live flag sweep", v, word(p[2:0], p[3], 3'b000, 1'b0, 1'b0));
      end
      ch_pass = '0; agc_strong = 0;
      @(negedge clk);

      // R9 / R11 parity
      parity_err = 1'b1;
      @(negedge clk);
      chk("R11 alert low on parity", {{(W-1){1'b0}}, alert_n}, 0);
      do_read(v);
      chk("R9 parity flag set", v, word(0, 0, 0, 0, 1));
      parity_err = 1'b0;
      @(negedge clk);
      chk("R11 alert released", {{(W-1){1'b0}}, alert_n}, 1);

      // R4 / R11 / R3 alarm
      alarm_pulse = 1'b1;
      @(negedge clk);
      alarm_pulse = 1'b0;
      chk("R11 alarm masked", {{(W-1){1'b0}}, alert_n}, 1);
      alarm_alert_en = 1'b1;
      #1;
      chk("R11 alarm enabled", {{(W-1){1'b0}}, alert_n}, 0);
      @(negedge clk);
      do_read(v);
      chk("R3 R4 read shows alarm", v, word(0, 0, 0, 1, 0));
      chk("R11 alert after read clear", {{(W-1){1'b0}}, alert_n}, 1);
      do_read(v);
      chk("R3 alarm cleared by read", v, word(0, 0, 0, 0, 0));

      // R4 same-cycle read and alarm
      alarm_pulse = 1'b1;
      do_read(v);
      alarm_pulse = 1'b0;
      chk("R3 capture before set", v, word(0, 0, 0, 0, 0));
      do_read(v);
      chk("R4 set wins over read", v, word(0, 0, 0, 1, 0));
      alarm_alert_en = 1'b0;

      // R5 sleep
      alarm_pulse = 1'b1;
      @(negedge clk);
      alarm_pulse = 1'b0;
      ch_pass = 3'b101;
      @(negedge clk);
      sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
      do_read(v);
      chk("R5 sleep leaves bits", v, word(3'b101, 0, 0, 1, 0));
      ch_pass = '0;
      @(negedge clk);

      // R6 thresholds per channel
      for (int ch = 0; ch < NCH; ch++) begin
         for (int k = 0; k < 3; k++) begin
            pulse_soft();
            ticks(ch, ns[k]);
            ch_carrier[ch] = 1'b0;
            idle(2);
            do_read(v);
            chk("R6 wake threshold", v[4:2],
                (ns[k] >= 64) ? (3'b001 << ch) : 3'b000);
         end
         idle(5);
         do_read(v);
         chk("R6 wake sticky", v[4:2], 3'b001 << ch);
      end

      // R7 carrier drop restarts
      pulse_soft();
      ticks(1, 40);
      ch_carrier[1] = 1'b0;
      @(negedge clk);
      ticks(1, 40);
      do_read(v);
      chk("R7 restart after drop", v[4:2], 3'b000);
      ticks(1, 24);
      @(negedge clk);
      do_read(v);
      chk("R7 count completes after restart", v[4:2], 3'b010);
      ch_carrier[1] = 1'b0;

      // R6 pause in ticks with carrier up does not restart
      pulse_soft();
      ticks(2, 32);
      idle(5);
      ticks(2, 31);
      do_read(v);
      chk("R6 pause holds count", v[4:2], 3'b000);
      ticks(2, 1);
      @(negedge clk);
      do_read(v);
      chk("R6 64th tick after pause", v[4:2], 3'b100);
      ch_carrier[2] = 1'b0;

      // R10 soft reset
      ticks(0, 64);
      ch_carrier[0] = 1'b0;
      ch_pass = 3'b111; agc_strong = 1'b1; parity_err = 1'b1;
      alarm_pulse = 1'b1;
      @(negedge clk);
      alarm_pulse = 1'b0;
      @(negedge clk);
      pulse_soft();
      do_read(v);
      chk("R10 soft reset clears 8..2 only", v, word(0, 0, 0, 1, 1));
      do_read(v2);
      chk("R8 R3 flags return after soft reset", v2, word(3'b111, 1, 0, 0, 1));
      ch_pass = '0; agc_strong = 0; parity_err = 0;
      idle(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule